// File: doc/BRIEF.md
# Region-Safe Sequential Burst Sequencer

This block turns one request for a multi-word transfer into the beat-by-beat address stream of a sequential bus. The request gives a start address, a word count and a direction. The block then presents one beat at a time. The first beat of a run is flagged as non-sequential, and every following beat of the same run is flagged as sequential. The address advances by one word each time the bus takes a beat.

Protection and mapping regions are 1KB in size, and the two sides of a region edge may have different properties. For that reason, no sequential run may cross a region edge. When the next beat would land on the first word of a new region, the block ends the current run. It restarts the transfer with a non-sequential beat that carries the full address. Downstream memory controllers can then treat each sequential run as lying inside one region, for example as one DRAM page.

The block is used for multi-word loads and stores to uncached space, 8-word line fills, and 4- or 8-word write-backs. It holds at most one transfer at a time. It raises a one-cycle completion pulse after the final beat is taken.

Top module: `burst_splitter`

## Requirements
- R1: After reset, `bus_valid` and `done` are low and `req_ready` is high.
- R2: `req_ready` is high exactly when no transfer is in progress. A request is taken when `req_valid` and `req_ready` are both high. Its first beat appears in the next cycle with `bus_seq` low, at the request address with bits [1:0] cleared, and with `bus_write` equal to the request's `req_write`.
- R3: Each beat that the bus accepts (`bus_valid` and `bus_ready` both high) is followed by the next beat at an address 4 higher. The next beat is presented in the following cycle.
- R4: Within one run, every beat after the first has `bus_seq` high.
- R5: A beat whose address has bits [9:0] equal to zero and that is not the first beat of the transfer is presented with `bus_seq` low. This beat carries its full address and starts a new run. No beat with `bus_seq` high ever has address bits [9:0] equal to zero.
- R6: While `bus_valid` is high and `bus_ready` is low, the beat's address, `bus_seq` and `bus_write` stay unchanged in the next cycle.
- R7: A request with `req_words` equal to N, where 1 ≤ N ≤ 16, produces exactly N accepted beats. A count above 16 is treated as 16.
- R8: A request with `req_words` equal to zero is ignored. It produces no beat and no `done` pulse, and `req_ready` stays high.
- R9: `done` is high for exactly one cycle, the cycle after the final beat is accepted. In that same cycle `bus_valid` is low and `req_ready` is high.
- R10: A request presented while a transfer is in progress is refused (`req_ready` is low). It has no effect on the beats of the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 32 | Start byte address; bits [1:0] are ignored |
| req_words | input | 5 | Number of words (0 ignored, above 16 clamped) |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_ready | output | 1 | Block is idle and takes a request |
| bus_valid | output | 1 | A beat is presented |
| bus_addr | output | 32 | Word-aligned address of the current beat |
| bus_write | output | 1 | Direction of the current beat |
| bus_seq | output | 1 | 1 = sequential beat, 0 = start of a run |
| bus_ready | input | 1 | Bus accepts the presented beat this cycle |
| done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
A wrong remaining-word count shows up at the ports as a `done` pulse that comes one beat early or late, or as a beat missing or extra at the end of the transfer. A wrong address register or a faulty region-edge decision shows up in the very next accepted beat. The symptom is either a wrong address or a sequential flag set on the first word of a region. A stall that is mishandled shows up one cycle later, as an address that moves while `bus_ready` is held low. The bench compares every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/burst_splitter_pkg.sv
package burst_splitter_pkg;

    typedef enum logic [0:0] {
        BS_IDLE = 1'b0,
        BS_RUN  = 1'b1
    } bs_state_e;

    localparam int unsigned BS_WORD_BYTES = 4;

endpackage

// File: rtl/bs_addr_step.sv
module bs_addr_step #(
    parameter int unsigned AW           = 32,
    parameter int unsigned REGION_BYTES = 1024
) (
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr,
    output logic          nxt_region_start
);
    localparam int unsigned RB = $clog2(REGION_BYTES);

    always_comb begin
        nxt_addr         = cur_addr + AW'(burst_splitter_pkg::BS_WORD_BYTES);
        nxt_region_start = (nxt_addr[RB-1:0] == '0);
    end
endmodule

// File: rtl/bs_count_clamp.sv
module bs_count_clamp #(
    parameter int unsigned CW        = 5,
    parameter int unsigned MAX_WORDS = 16
) (
    input  logic [CW-1:0] raw_count,
    output logic [CW-1:0] eff_count,
    output logic          is_zero
);
    always_comb begin
        if (raw_count > CW'(MAX_WORDS)) begin
            eff_count = CW'(MAX_WORDS);
        end else begin
            eff_count = raw_count;
        end
        is_zero = (raw_count == '0);
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
    parameter int unsigned AW           = 32,
    parameter int unsigned MAX_WORDS    = 16,
    parameter int unsigned REGION_BYTES = 1024,
    localparam int unsigned CW          = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_words,
    input  logic          req_write,
    output logic          req_ready,
    output logic          bus_valid,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic          bus_seq,
    input  logic          bus_ready,
    output logic          done
);
    import burst_splitter_pkg::*;

    typedef struct packed {
        bs_state_e     state;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic          write;
        logic          seq;
        logic          done;
    } bs_regs_t;

    bs_regs_t      r_q, r_d;
    logic [AW-1:0] step_addr;
    logic          step_edge;
    logic [CW-1:0] eff_words;
    logic          zero_words;

    bs_addr_step #(
        .AW           (AW),
        .REGION_BYTES (REGION_BYTES)
    ) u_step (
        .cur_addr         (r_q.addr),
        .nxt_addr         (step_addr),
        .nxt_region_start (step_edge)
    );

    bs_count_clamp #(
        .CW        (CW),
        .MAX_WORDS (MAX_WORDS)
    ) u_clamp (
        .raw_count (req_words),
        .eff_count (eff_words),
        .is_zero   (zero_words)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            BS_IDLE: begin
                if (req_valid && !zero_words) begin
                    r_d.state = BS_RUN;
                    r_d.addr  = {req_addr[AW-1:2], 2'b00};
                    r_d.left  = eff_words;
                    r_d.write = req_write;
                    r_d.seq   = 1'b0;
                end
            end
            BS_RUN: begin
                if (bus_ready) begin
                    if (r_q.left == CW'(1)) begin
                        r_d.state = BS_IDLE;
                        r_d.left  = '0;
                        r_d.seq   = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr = step_addr;
                        r_d.left = r_q.left - CW'(1);
                        r_d.seq  = !step_edge;
                    end
                end
            end
            default: r_d.state = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: BS_IDLE, addr: '0, left: '0, write: 1'b0, seq: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == BS_IDLE);
    assign bus_valid = (r_q.state == BS_RUN);
    assign bus_addr  = r_q.addr;
    assign bus_write = r_q.write;
    assign bus_seq   = r_q.seq;
    assign done      = r_q.done;
endmodule

// File: rtl/burst_splitter_chk.sv
module burst_splitter_chk #(
    parameter int unsigned AW           = 32,
    parameter int unsigned MAX_WORDS    = 16,
    parameter int unsigned REGION_BYTES = 1024,
    localparam int unsigned CW          = $clog2(MAX_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [CW-1:0] req_words,
    input logic          req_write,
    input logic          req_ready,
    input logic          bus_valid,
    input logic [AW-1:0] bus_addr,
    input logic          bus_write,
    input logic          bus_seq,
    input logic          bus_ready,
    input logic          done
);
    localparam int unsigned RB = $clog2(REGION_BYTES);

    logic [CW:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n || req_ready) begin
            beats_q <= '0;
        end else if (bus_valid && bus_ready) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_valid); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !req_ready) |=> (bus_valid -> (bus_addr == $past(bus_addr) + AW'(4)))); // R3
    AST_NO_SEQ_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_seq) |-> (bus_addr[RB-1:0] != '0)); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_seq) && $stable(bus_write))); // R6
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (beats_q < (CW+1)'(MAX_WORDS))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !bus_valid)); // R9
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[1:0] == 2'b00)); // R2
endmodule

bind burst_splitter burst_splitter_chk #(
    .AW           (AW),
    .MAX_WORDS    (MAX_WORDS),
    .REGION_BYTES (REGION_BYTES)
) u_chk (.*);

// File: tb/burst_splitter_bench.sv
module burst_splitter_bench;
    localparam int AW = 32;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_words = '0;
    logic          req_write = 1'b0;
    logic          req_ready;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic          bus_seq;
    logic          bus_ready = 1'b1;
    logic          done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  zero_phase = 0;
    bit  prev_stall = 0;
    bit  first_flag_q[$];

    int unsigned exp_addr_q[$];
    bit          exp_seq_q[$];
    bit          m_write = 0;
    bit          m_done = 0;

    always #2.5 clk = ~clk;

    burst_splitter u_burst_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_words(req_words), .req_write(req_write), .req_ready(req_ready),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_seq(bus_seq), .bus_ready(bus_ready), .done(done)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: a queue of expected beats per request.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_addr_q.delete();
            exp_seq_q.delete();
            first_flag_q.delete();
            m_done <= 0;
        end else begin
            m_done <= 0;
            if (exp_addr_q.size() > 0) begin
                if (bus_ready) begin
                    void'(exp_addr_q.pop_front());
                    void'(exp_seq_q.pop_front());
                    void'(first_flag_q.pop_front());
                    if (exp_addr_q.size() == 0) m_done <= 1;
                end
            end else if (req_valid) begin
                int n;
                int unsigned base;
                n = int'(req_words);
                if (n > 16) n = 16;
                base = req_addr & 32'hFFFF_FFFC;
                m_write = req_write;
                for (int i = 0; i < n; i++) begin
                    int unsigned a;
                    a = base + 4 * i;
                    exp_addr_q.push_back(a);
                    exp_seq_q.push_back((i != 0) && ((a % 1024) != 0));
                    first_flag_q.push_back(i == 0);
                end
            end
            prev_stall <= bus_valid && !bus_ready;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ev;
            ev = exp_addr_q.size() > 0;
            chk(req_ready == !ev, (req_valid && ev) ? "R10" : "R2", "req_ready", req_ready, !ev);
            chk(bus_valid == ev, zero_phase ? "R8" : "R7", "bus_valid", bus_valid, ev);
            chk(done == m_done, zero_phase ? "R8" : "R9", "done", done, m_done);
            if (ev && bus_valid) begin
                string ta;
                string ts;
                ta = prev_stall ? "R6" : (first_flag_q[0] ? "R2" : "R3");
                ts = first_flag_q[0] ? "R2" : (exp_seq_q[0] ? "R4" : "R5");
                chk(bus_addr == exp_addr_q[0], ta, "bus_addr", bus_addr, exp_addr_q[0]);
                chk(bus_seq == exp_seq_q[0], ts, "bus_seq", bus_seq, exp_seq_q[0]);
                chk(bus_write == m_write, "R2", "bus_write", bus_write, m_write);
            end
        end
    end

    task automatic request(int unsigned a, int n, bit w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_words = CW'(n); req_write = w;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        while (exp_addr_q.size() > 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bus_valid == 0, "R1", "bus_valid after reset", bus_valid, 0);
        chk(done == 0, "R1", "done after reset", done, 0);
        chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);

        request(32'h0000_0100, 8, 0); drain();        // R3 R4 plain line fill
        request(32'h0000_03F0, 16, 1); drain();       // R5 split at 0x400
        request(32'h0000_07FE, 4, 0); drain();        // R2 alignment, R5 split at 0x800
        request(32'h0001_0000, 20, 1); drain();       // R7 clamp to 16
        request(32'h0000_2000, 1, 0); drain();        // R7 single word

        zero_phase = 1;                               // R8 zero count ignored
        request(32'h0000_3000, 0, 1);
        repeat (4) @(negedge clk);
        zero_phase = 0;

        // R6 stalls with an irregular ready pattern across an edge
        fork
            request(32'h0000_0BE0, 16, 0);
            begin
                for (int k = 0; k < 60; k++) begin
                    @(negedge clk);
                    bus_ready = ((k % 3) != 1) && ((k % 7) != 4);
                end
                bus_ready = 1;
            end
        join
        drain();

        // R10 request while busy is refused
        bus_ready = 0;
        request(32'h0000_0400, 6, 1);
        repeat (2) @(negedge clk);
        req_valid = 1; req_addr = 32'h0000_5000; req_words = 5'd3; req_write = 0;
        repeat (3) @(negedge clk);
        req_valid = 0;
        bus_ready = 1;
        drain();

        // back-to-back: new request in the done cycle
        request(32'h0000_13F8, 4, 0);
        request(32'h0000_1800, 2, 1);
        drain();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule